// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block watches a stream of 12-bit conversion results and sorts each one into one of three zones set by a programmable pair of bounds: below the lower bound, inside the window, or above the upper bound. Each zone has its own enable. When a valid result lands in an enabled zone, the matching sticky zone flag is raised, unless the flag-hold control is set. The result is also counted as a qualifying match.

A small state machine tracks runs of consecutive qualifying matches. When a run reaches the programmed 4-bit threshold, the block raises a sticky event flag and starts counting again from zero. Any valid result that hits no enabled zone restarts the run. Software clears all four flags by writing ones through a clear strobe and mask. The interrupt line is the event flag gated by an interrupt enable.

The state machine has three states. `MON_OFF` holds while the monitor is disabled, with the count forced to zero. `MON_ARMED` means enabled with a zero count. `MON_TALLY` means enabled with a partial run in progress. The transitions are as follows:
- enable dropping moves any state to `MON_OFF`.
- A qualifying result below the threshold moves to `MON_TALLY`.
- A miss or a threshold hit moves to `MON_ARMED`.
- Enable with no result moves `MON_OFF` to `MON_ARMED`.

A result that arrives in the first enabled cycle is already processed.

Top module: `winmon_top`

## Requirements
- R1: The lower bound is taken from `bounds_word[11:0]` and the upper bound from `bounds_word[27:16]`; all other bits of `bounds_word` have no effect.
- R2: A valid result strictly less than the lower bound sets `flag_below` when `cfg_below_en` is 1.
- R3: A valid result with lower ≤ result ≤ upper (both bounds included) sets `flag_inside` when `cfg_inside_en` is 1.
- R4: A valid result strictly greater than the upper bound sets `flag_above` when `cfg_above_en` is 1.
- R5: Each valid result that hits an enabled zone adds one to the run count, and each valid result that hits none resets the count to 0. When the count reaches `cfg_match_thr`, `flag_irq` is set and the count returns to 0.
- R6: A `cfg_match_thr` of 0 behaves as 1, so every qualifying result sets `flag_irq`.
- R7: With `cfg_hold_flags` = 1, the zone flags are not set by results, while counting and `flag_irq` work unchanged. With 0, the zone flags update on each match.
- R8: While `cfg_enable` = 0, results are ignored (no flag is set) and the run count is held at 0, so a partial run is lost.
- R9: A cycle with `clr_wr` = 1 clears each flag whose `clr_mask` bit is 1: bit 0 `flag_irq`, bit 1 `flag_below`, bit 2 `flag_inside`, bit 3 `flag_above`. Flags whose mask bit is 0 are unchanged, and a set in the same cycle wins over a clear.
- R10: `irq` is 1 exactly when `flag_irq` and `cfg_irq_en` are both 1. `flag_irq` is still set while `cfg_irq_en` is 0.
- R11: All flags and `irq` are 0 after reset. Flag updates from a result appear at the first rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_data | input | 12 | Conversion result |
| cfg_enable | input | 1 | Monitor enable |
| cfg_irq_en | input | 1 | Interrupt line enable |
| cfg_below_en | input | 1 | Below-zone enable |
| cfg_inside_en | input | 1 | Inside-zone enable |
| cfg_above_en | input | 1 | Above-zone enable |
| cfg_hold_flags | input | 1 | 1 = zone flags not updated by results |
| cfg_match_thr | input | 4 | Consecutive-match threshold (0 acts as 1) |
| bounds_word | input | 32 | Lower bound in 11:0, upper bound in 27:16 |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | 4 | Write-1-to-clear mask for the four flags |
| flag_irq | output | 1 | Sticky run-threshold event flag |
| flag_below | output | 1 | Sticky below-zone flag |
| flag_inside | output | 1 | Sticky inside-zone flag |
| flag_above | output | 1 | Sticky above-zone flag |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps every zone-enable combination against results on, just inside and just outside each bound. This catches an off-by-one comparison, which would move a boundary value into the wrong zone, and a window that excludes its own bounds. It also runs every threshold from 0 to 15 with misses inserted at fixed intervals. A counter that failed to restart after a miss or a fire would raise `flag_irq` early, and a threshold of 0 handled literally would never fire. Clears are issued in the same cycle as sets to show that the set wins, and a partial run is interrupted by a disable to show that it is discarded rather than resumed.

// File: rtl/winmon_pkg.sv
package winmon_pkg;

    localparam int unsigned ZONE_N = 3;

    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,
        MON_ARMED = 2'd1,
        MON_TALLY = 2'd2
    } mon_state_e;

    // bit order: 0 below, 1 inside, 2 above
    typedef logic [ZONE_N-1:0] zone_vec_t;

endpackage

// File: rtl/winmon_zone_classify.sv
module winmon_zone_classify
    import winmon_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] lo_bound,
    input  logic [SAMPLE_W-1:0] hi_bound,
    output zone_vec_t           zone_hit
);

    logic is_below;
    logic is_above;

    always_comb begin
        is_below    = sample < lo_bound;
        is_above    = sample > hi_bound;
        zone_hit[0] = is_below;
        zone_hit[1] = !is_below && !is_above;
        zone_hit[2] = is_above;
    end

endmodule

// File: rtl/winmon_match_fsm.sv
module winmon_match_fsm
    import winmon_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sample_valid,
    input  logic             hit,
    input  logic [CNT_W-1:0] thr,
    output logic             fire
);

    localparam logic [CNT_W:0] ONE_EXT = (CNT_W+1)'(1);

    mon_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   thr_eff;
    logic [CNT_W:0]   cnt_inc;
    logic             run_step;

    always_comb begin
        thr_eff = (thr == '0) ? ONE_EXT : {1'b0, thr};
        cnt_inc = {1'b0, cnt_q} + ONE_EXT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MON_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        fire     = 1'b0;
        run_step = 1'b0;
        unique case (st_q)
            MON_OFF: begin
                cnt_d = '0;
                if (enable) begin
                    st_d     = MON_ARMED;
                    run_step = sample_valid;
                end
            end
            MON_ARMED, MON_TALLY: begin
                if (!enable) begin
                    st_d  = MON_OFF;
                    cnt_d = '0;
                end else begin
                    run_step = sample_valid;
                end
            end
            default: begin
                st_d  = MON_OFF;
                cnt_d = '0;
            end
        endcase
        if (run_step) begin
            if (!hit) begin
                st_d  = MON_ARMED;
                cnt_d = '0;
            end else if (cnt_inc >= thr_eff) begin
                fire  = 1'b1;
                st_d  = MON_ARMED;
                cnt_d = '0;
            end else begin
                st_d  = MON_TALLY;
                cnt_d = cnt_inc[CNT_W-1:0];
            end
        end
    end

    assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q == MON_OFF && cnt_q == '0));

    assert_tally_has_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MON_TALLY) |-> (cnt_q != '0));

    assert_armed_is_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MON_TALLY) |-> (cnt_q == '0));

    assert_fire_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q == MON_ARMED && cnt_q == '0));

endmodule

// File: rtl/winmon_flag_bank.sv
module winmon_flag_bank
    import winmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      sample_valid,
    input  logic      hold,
    input  zone_vec_t zone_qual,
    input  logic      fire,
    input  logic      clr_wr,
    input  logic [3:0] clr_mask,
    output zone_vec_t zone_flag,
    output logic      event_flag
);

    zone_vec_t zone_set;

    always_comb begin
        zone_set = (enable && sample_valid && !hold) ? zone_qual : '0;
    end

    for (genvar z = 0; z < ZONE_N; z++) begin : g_zone
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                zone_flag[z] <= 1'b0;
            end else if (zone_set[z]) begin
                zone_flag[z] <= 1'b1;
            end else if (clr_wr && clr_mask[z+1]) begin
                zone_flag[z] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_flag <= 1'b0;
        end else if (fire) begin
            event_flag <= 1'b1;
        end else if (clr_wr && clr_mask[0]) begin
            event_flag <= 1'b0;
        end
    end

    assert_hold_freezes_zones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr_wr) |=> $stable(zone_flag));

    assert_event_from_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_flag) |-> $past(fire));

    assert_below_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[1] && !zone_set[0]) |=> !zone_flag[0]);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> event_flag);

endmodule

// File: rtl/winmon_top.sv
module winmon_top
    import winmon_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid,
    input  logic [SAMPLE_W-1:0] res_data,
    input  logic                cfg_enable,
    input  logic                cfg_irq_en,
    input  logic                cfg_below_en,
    input  logic                cfg_inside_en,
    input  logic                cfg_above_en,
    input  logic                cfg_hold_flags,
    input  logic [CNT_W-1:0]    cfg_match_thr,
    input  logic [WORD_W-1:0]   bounds_word,
    input  logic                clr_wr,
    input  logic [3:0]          clr_mask,
    output logic                flag_irq,
    output logic                flag_below,
    output logic                flag_inside,
    output logic                flag_above,
    output logic                irq
);

    localparam int unsigned LO_LSB = 0;
    localparam int unsigned HI_LSB = WORD_W / 2;

    logic [SAMPLE_W-1:0] lo_bound;
    logic [SAMPLE_W-1:0] hi_bound;
    logic                unused_bounds;
    zone_vec_t           zone_hit;
    zone_vec_t           zone_qual;
    zone_vec_t           zone_flag;
    logic                any_hit;
    logic                fire;

    always_comb begin
        lo_bound      = bounds_word[LO_LSB +: SAMPLE_W];
        hi_bound      = bounds_word[HI_LSB +: SAMPLE_W];
        unused_bounds = ^bounds_word;
        zone_qual     = zone_hit & {cfg_above_en, cfg_inside_en, cfg_below_en};
        any_hit       = |zone_qual;
    end

    winmon_zone_classify #(.SAMPLE_W(SAMPLE_W)) u_classify (
        .sample   (res_data),
        .lo_bound (lo_bound),
        .hi_bound (hi_bound),
        .zone_hit (zone_hit)
    );

    winmon_match_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (cfg_enable),
        .sample_valid (res_valid),
        .hit          (any_hit),
        .thr          (cfg_match_thr),
        .fire         (fire)
    );

    winmon_flag_bank u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (cfg_enable),
        .sample_valid (res_valid),
        .hold         (cfg_hold_flags),
        .zone_qual    (zone_qual),
        .fire         (fire),
        .clr_wr       (clr_wr),
        .clr_mask     (clr_mask),
        .zone_flag    (zone_flag),
        .event_flag   (flag_irq)
    );

    always_comb begin
        flag_below  = zone_flag[0];
        flag_inside = zone_flag[1];
        flag_above  = zone_flag[2];
        irq         = flag_irq && cfg_irq_en;
    end

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq);

    assert_one_zone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && lo_bound <= hi_bound) |-> ($countones(zone_hit) == 1));

    assert_disabled_no_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !fire);

endmodule

// File: tb/sim_winmon_top.sv
module sim_winmon_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic        cfg_enable = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_below_en = 1'b0;
    logic        cfg_inside_en = 1'b0;
    logic        cfg_above_en = 1'b0;
    logic        cfg_hold_flags = 1'b0;
    logic [3:0]  cfg_match_thr = '0;
    logic [31:0] bounds_word = '0;
    logic        clr_wr = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic        flag_irq, flag_below, flag_inside, flag_above, irq;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt = 0;
    logic [3:0] m_flag = '0;   // bit0 irq flag, 1 below, 2 inside, 3 above

    always #4 clk = ~clk;

    winmon_top u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .cfg_enable(cfg_enable), .cfg_irq_en(cfg_irq_en), .cfg_below_en(cfg_below_en),
        .cfg_inside_en(cfg_inside_en), .cfg_above_en(cfg_above_en),
        .cfg_hold_flags(cfg_hold_flags), .cfg_match_thr(cfg_match_thr),
        .bounds_word(bounds_word), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .flag_irq(flag_irq), .flag_below(flag_below), .flag_inside(flag_inside),
        .flag_above(flag_above), .irq(irq)
    );

    task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got irq/above/inside/below/event=%b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] observed();
        return {irq, flag_above, flag_inside, flag_below, flag_irq};
    endfunction

    function automatic logic [4:0] expected();
        return {m_flag[0] & cfg_irq_en, m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
    endfunction

    // one cycle of stimulus, called just after a falling edge
    task automatic step(input logic v, input logic [11:0] d, input logic cw,
                        input logic [3:0] cm, input string tag);
        int lo, hi, thr_e;
        logic [3:0] setv;
        res_valid = v; res_data = d; clr_wr = cw; clr_mask = cm;
        lo = int'(bounds_word[11:0]);
        hi = int'(bounds_word[27:16]);
        thr_e = (cfg_match_thr == 0) ? 1 : int'(cfg_match_thr);
        setv = '0;
        if (!cfg_enable) begin
            m_cnt = 0;
        end else if (v) begin
            setv[1] = (int'(d) < lo) && cfg_below_en;
            setv[2] = (int'(d) >= lo) && (int'(d) <= hi) && cfg_inside_en;
            setv[3] = (int'(d) > hi) && cfg_above_en;
            if (setv[3:1] != 3'b000) begin
                m_cnt++;
                if (m_cnt >= thr_e) begin
                    setv[0] = 1'b1;
                    m_cnt = 0;
                end
            end else begin
                m_cnt = 0;
            end
            if (cfg_hold_flags) setv[3:1] = 3'b000;
        end
        for (int b = 0; b < 4; b++) begin
            if (setv[b]) m_flag[b] = 1'b1;
            else if (cw && cm[b]) m_flag[b] = 1'b0;
        end
        @(negedge clk);
        res_valid = 1'b0; clr_wr = 1'b0; clr_mask = '0;
        check(observed(), expected(), tag);
    endtask

    task automatic clear_all();
        step(1'b0, 12'd0, 1'b1, 4'hF, "R9");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(observed(), 5'b0, "R11 reset");

        // zone sweep; upper nibbles set to junk (R1)
        cfg_enable = 1'b1; cfg_irq_en = 1'b1; cfg_match_thr = 4'd15;
        bounds_word = {4'hF, 12'd3000, 4'hF, 12'd1000};
        for (int m = 0; m < 8; m++) begin
            cfg_below_en = m[0]; cfg_inside_en = m[1]; cfg_above_en = m[2];
            for (int k = 0; k < 9; k++) begin
                int val;
                case (k)
                    0: val = 0;     1: val = 999;   2: val = 1000;
                    3: val = 1001;  4: val = 2000;  5: val = 2999;
                    6: val = 3000;  7: val = 3001;  default: val = 4095;
                endcase
                step(1'b1, 12'(val), 1'b0, 4'h0,
                     (val < 1000) ? "R2 R1" : (val > 3000) ? "R4 R1" : "R3 R1");
                clear_all();
            end
        end
        // degenerate window: both bounds equal
        bounds_word = {4'h0, 12'd2048, 4'h0, 12'd2048};
        cfg_below_en = 1'b1; cfg_inside_en = 1'b1; cfg_above_en = 1'b1;
        step(1'b1, 12'd2048, 1'b0, 4'h0, "R3 equal bounds");
        step(1'b1, 12'd2047, 1'b0, 4'h0, "R2 equal bounds");
        step(1'b1, 12'd2049, 1'b0, 4'h0, "R4 equal bounds");
        clear_all();

        // threshold sweep, misses every 11th result, event flag cleared every cycle
        bounds_word = {4'h0, 12'd200, 4'h0, 12'd100};
        cfg_below_en = 1'b0; cfg_inside_en = 1'b1; cfg_above_en = 1'b0;
        for (int t = 0; t < 16; t++) begin
            cfg_match_thr = 4'(t);
            step(1'b1, 12'd50, 1'b1, 4'hF, "R5 restart");
            for (int i = 0; i < 40; i++) begin
                step(1'b1, (i % 11 == 10) ? 12'd50 : 12'd150, 1'b1, 4'b0001,
                     (t == 0) ? "R6" : "R5 R9");
            end
        end
        clear_all();

        // hold mode
        cfg_hold_flags = 1'b1; cfg_match_thr = 4'd2;
        cfg_below_en = 1'b1; cfg_inside_en = 1'b1; cfg_above_en = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b1, 12'(i * 90), 1'b0, 4'h0, "R7 hold");
        cfg_hold_flags = 1'b0;
        step(1'b1, 12'd10, 1'b0, 4'h0, "R7 auto");
        clear_all();

        // disable drops a partial run
        cfg_match_thr = 4'd3;
        step(1'b1, 12'd150, 1'b0, 4'h0, "R8");
        step(1'b1, 12'd150, 1'b0, 4'h0, "R8");
        cfg_enable = 1'b0;
        step(1'b1, 12'd150, 1'b0, 4'h0, "R8 ignored");
        step(1'b1, 12'd10, 1'b0, 4'h0, "R8 ignored");
        cfg_enable = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 12'd150, 1'b0, 4'h0, "R8 recount");
        clear_all();

        // interrupt gating and per-bit clears
        cfg_irq_en = 1'b0; cfg_match_thr = 4'd1;
        step(1'b1, 12'd10, 1'b0, 4'h0, "R10 gated");
        step(1'b1, 12'd150, 1'b0, 4'h0, "R10 gated");
        step(1'b1, 12'd900, 1'b0, 4'h0, "R10 gated");
        cfg_irq_en = 1'b1;
        step(1'b0, 12'd0, 1'b0, 4'h0, "R10 open");
        step(1'b0, 12'd0, 1'b1, 4'b0010, "R9 below only");
        step(1'b0, 12'd0, 1'b1, 4'b1000, "R9 above only");
        step(1'b0, 12'd0, 1'b1, 4'b0001, "R9 event only");
        step(1'b0, 12'd0, 1'b1, 4'b0000, "R9 empty mask");
        step(1'b0, 12'd0, 1'b1, 4'b0100, "R9 inside only");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule